// File: doc/BRIEF.md
# PCI Base Address Window Decoder

This block holds the address-decode state of a type-0 PCI configuration header: six base address slots at header offsets 0x10 to 0x24 and the two enable bits of the command register. Each slot is fixed by parameter as unused, I/O, 32-bit memory or 64-bit memory. A 64-bit slot also takes the slot above it as its upper half. Each slot also has a prefetchable flag and a power-of-two window size of at least 16 bytes.

Configuration accesses arrive on one port. The block checks their alignment, rebases the address to its own function and answers them in the same cycle. Writes take effect at the next clock edge. A second port presents I/O or memory addresses. In the same cycle it reports which enabled window claims the address, and the offset inside it, or a master abort when no window claims it.

Top module: `pci_window_decoder`

## Requirements
- R1: After reset the command enables and all base address bits are zero, so no address decodes. A BAR read then returns only its type code.
- R2: A dword write to a BAR stores only the address bits at or above the window size. A read returns those bits ORed with the type code in bits [3:0]: I/O gives 0x1, 32-bit memory gives {pref,3'b000}, and 64-bit memory gives {pref,3'b100}. Writing all ones therefore reads back the sizing mask.
- R3: For a window of 4 GiB or more, the low dword keeps no address bits. The upper slot's writable bits start at bit (log2 size - 32).
- R4: The upper half of a 64-bit BAR sits at the next slot (offset +4) and holds address bits 63:32. Decode compares all 64 bits. A 32-bit or I/O window only claims addresses whose bits 63:32 are zero.
- R5: The command dword is at header offset 0x04. Bit 0 enables every I/O window and bit 1 enables every memory window. Other command bits read as zero.
- R6: dec_space selects 0 for I/O and 1 for memory. On a claim, dec_hit is 1, dec_bar gives the slot index and dec_offset gives the address bits below the window size.
- R7: A dec_valid address that no enabled window of the matching space claims gives dec_master_abort=1 and dec_hit=0.
- R8: A BAR rewrite or a command change moves the decode from the clock edge that commits the write. The old base no longer hits in the cycle after.
- R9: A configuration access is misaligned when cfg_size is 3, or when the offset is not a multiple of the access size (cfg_size 0=1, 1=2, 2=4 bytes). Such an access gives cfg_status=1 (target abort) and changes no state.
- R10: The header offset is cfg_addr minus (DEV_NUM<<11 | FUNC_NUM<<8). A result outside 0..255 gives cfg_status=2 (master abort) and changes no state. A successful access gives status 0.
- R11: When enabled windows overlap, the lowest slot index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_valid | input | 1 | Configuration access present |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 16 | Configuration address before rebasing |
| cfg_size | input | 2 | Access size code: 0=1, 1=2, 2=4 bytes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, shifted down by the byte offset |
| cfg_status | output | 2 | 0 ok, 1 target abort, 2 master abort |
| dec_valid | input | 1 | Decode request present |
| dec_space | input | 1 | 0 = I/O, 1 = memory |
| dec_addr | input | 64 | Address to decode |
| dec_hit | output | 1 | A window claims the address |
| dec_bar | output | 3 | Index of the claiming slot |
| dec_offset | output | 64 | Offset inside the claiming window |
| dec_master_abort | output | 1 | No enabled window claims the address |

## Verification
A configuration write that moves a BAR and a decode of that BAR's old base can fall in the same cycle. The bench presents both together and checks that the decode still claims the old base in that cycle. It then checks that, after the edge, the old base aborts and the new base hits. The same bench also turns the memory enable off under a live window and checks that the abort follows on the next cycle.

// File: rtl/pci_window_decoder.sv
module pci_window_decoder #(
  parameter logic [11:0] SLOT_KIND = 12'h336,
  parameter logic [5:0]  SLOT_PREF = 6'b000100,
  parameter logic [35:0] SLOT_LOG2 = {6'd0, 6'd33, 6'd0, 6'd20, 6'd8, 6'd12},
  parameter logic [4:0]  DEV_NUM   = 5'd2,
  parameter logic [2:0]  FUNC_NUM  = 3'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cfg_valid,
  input  logic        cfg_write,
  input  logic [15:0] cfg_addr,
  input  logic [1:0]  cfg_size,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic [1:0]  cfg_status,
  input  logic        dec_valid,
  input  logic        dec_space,
  input  logic [63:0] dec_addr,
  output logic        dec_hit,
  output logic [2:0]  dec_bar,
  output logic [63:0] dec_offset,
  output logic        dec_master_abort
);
  localparam int NSLOT = 6;
  localparam logic [15:0] FN_BASE = {DEV_NUM, FUNC_NUM, 8'h00};

  logic [1:0]             cmd_q;
  logic [NSLOT-1:0][31:0] bar_q;
  logic [NSLOT-1:0][31:0] wmask;
  logic [NSLOT-1:0][3:0]  tbits;
  logic [NSLOT-1:0]       slot_hit;
  logic [NSLOT-1:0][63:0] slot_off;

  genvar i;
  generate
    for (i = 0; i < NSLOT; i++) begin : g_slot
      localparam int PI = (i > 0) ? i - 1 : 0;
      localparam int NI = (i < NSLOT - 1) ? i + 1 : i;
      localparam logic [1:0] K = SLOT_KIND[2*i +: 2];
      localparam bit UP = (i > 0) && (SLOT_KIND[2*PI +: 2] == 2'd3);
      localparam int LG  = int'(SLOT_LOG2[6*i +: 6]);
      localparam int PLG = int'(SLOT_LOG2[6*PI +: 6]);
      localparam logic [63:0] SM  = ~((64'd1 << LG) - 64'd1);
      localparam logic [63:0] PSM = ~((64'd1 << PLG) - 64'd1);

      assign wmask[i] = UP ? PSM[63:32] : ((K != 2'd0) ? (SM[31:0] & 32'hFFFF_FFF0) : 32'h0);
      assign tbits[i] = (K == 2'd1) ? 4'b0001 :
                        (K == 2'd2) ? {SLOT_PREF[i], 3'b000} :
                        (K == 2'd3) ? {SLOT_PREF[i], 3'b100} : 4'b0000;

      if (K != 2'd0) begin : g_dec
        logic [63:0] base;
        logic        en;
        assign base = (K == 2'd3) ? {bar_q[NI], bar_q[i] & 32'hFFFF_FFF0}
                                  : {32'h0, bar_q[i] & 32'hFFFF_FFF0};
        assign en   = (K == 2'd1) ? (cmd_q[0] && !dec_space) : (cmd_q[1] && dec_space);
        assign slot_hit[i] = en && ((dec_addr & SM) == base);
        assign slot_off[i] = dec_addr & ~SM;
      end else begin : g_none
        assign slot_hit[i] = 1'b0;
        assign slot_off[i] = 64'h0;
      end
    end
  endgenerate

  always_comb begin
    dec_bar    = 3'd0;
    dec_offset = 64'h0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (slot_hit[s]) begin
        dec_bar    = 3'(s);
        dec_offset = slot_off[s];
      end
    end
  end

  assign dec_hit          = dec_valid && (|slot_hit);
  assign dec_master_abort = dec_valid && !(|slot_hit);

  logic [15:0] rel;
  logic [7:0]  off;
  logic        claimed, misaligned, access_ok, is_bar, is_cmd;
  logic [2:0]  bar_idx;
  logic [31:0] dword;

  assign rel        = cfg_addr - FN_BASE;
  assign off        = rel[7:0];
  assign claimed    = (rel[15:8] == 8'h00);
  assign misaligned = (cfg_size == 2'd3) ||
                      (cfg_size == 2'd1 && off[0]) ||
                      (cfg_size == 2'd2 && off[1:0] != 2'b00);
  assign access_ok  = cfg_valid && !misaligned && claimed;
  assign is_bar     = (off >= 8'h10) && (off < 8'h28);
  assign is_cmd     = (off[7:2] == 6'd1);
  assign bar_idx    = off[4:2] - 3'd4;

  assign dword = is_cmd ? {30'h0, cmd_q} :
                 is_bar ? (bar_q[bar_idx] | {28'h0, tbits[bar_idx]}) : 32'h0;

  assign cfg_rdata  = (access_ok && !cfg_write) ? (dword >> {off[1:0], 3'b000}) : 32'h0;
  assign cfg_status = !cfg_valid ? 2'd0 : misaligned ? 2'd1 : !claimed ? 2'd2 : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= 2'b00;
      bar_q <= '0;
    end else if (access_ok && cfg_write && off[1:0] == 2'b00) begin
      if (is_cmd && cfg_size != 2'd0)
        cmd_q <= cfg_wdata[1:0];
      if (is_bar && cfg_size == 2'd2)
        bar_q[bar_idx] <= cfg_wdata & wmask[bar_idx];
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmd_q == 2'b00 && !dec_hit));

  assert_space_gate_R5: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (dec_space ? cmd_q[1] : cmd_q[0]));

  assert_offset_align_R6: assert property (@(posedge clk) disable iff (rst)
    dec_hit |-> (dec_offset <= dec_addr && ((dec_addr - dec_offset) & 64'hF) == 64'h0));

  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (dec_hit != dec_master_abort));

  assert_misalign_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_write && cfg_status == 2'd1) |=> ($stable(cmd_q) && $stable(bar_q)));

  assert_unclaimed_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_write && cfg_status == 2'd2) |=> ($stable(cmd_q) && $stable(bar_q)));
endmodule

// File: tb/pci_window_decoder_test.sv
module pci_window_decoder_test;
  localparam logic [15:0] BASE = 16'h1100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_valid = 1'b0, cfg_write = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [1:0]  cfg_size = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  cfg_status;
  logic        dec_valid = 1'b0, dec_space = 1'b0;
  logic [63:0] dec_addr = '0;
  logic        dec_hit, dec_master_abort;
  logic [2:0]  dec_bar;
  logic [63:0] dec_offset;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pci_window_decoder uut (
    .clk(clk), .rst(rst),
    .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
    .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_status(cfg_status),
    .dec_valid(dec_valid), .dec_space(dec_space), .dec_addr(dec_addr),
    .dec_hit(dec_hit), .dec_bar(dec_bar), .dec_offset(dec_offset),
    .dec_master_abort(dec_master_abort)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [15:0] a, input logic [1:0] sz, input logic [31:0] d,
                        output logic [1:0] st);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_addr = a; cfg_size = sz; cfg_wdata = d;
    #1 st = cfg_status;
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0;
  endtask

  task automatic cfg_rd(input logic [15:0] a, input logic [1:0] sz,
                        output logic [31:0] d, output logic [1:0] st);
    @(negedge clk);
    cfg_valid = 1; cfg_write = 0; cfg_addr = a; cfg_size = sz;
    #1 d = cfg_rdata; st = cfg_status;
    cfg_valid = 0;
  endtask

  task automatic wr_ok(input string tag, input logic [7:0] o, input logic [1:0] sz, input logic [31:0] d);
    logic [1:0] st;
    cfg_wr(BASE + 16'(o), sz, d, st);
    chk(tag, 64'(st), 64'd0);
  endtask

  task automatic rd_exp(input string tag, input logic [7:0] o, input logic [31:0] exp);
    logic [31:0] d; logic [1:0] st;
    cfg_rd(BASE + 16'(o), 2'd2, d, st);
    chk(tag, 64'(d), 64'(exp));
  endtask

  task automatic dec_exp(input string tag, input logic sp, input logic [63:0] a,
                         input logic hit, input logic [2:0] bar, input logic [63:0] offs);
    @(negedge clk);
    dec_valid = 1; dec_space = sp; dec_addr = a;
    #1;
    chk(tag, {62'd0, dec_hit, dec_master_abort}, {62'd0, hit, !hit});
    if (hit) begin
      chk(tag, 64'(dec_bar), 64'(bar));
      chk(tag, dec_offset, offs);
    end
    dec_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic [1:0] st;
    cfg_rd(BASE + 16'h4, 2'd1, d, st);
    chk("R1 cmd after reset", 64'(d), 64'd0);
    chk("R10 status ok", 64'(st), 64'd0);
    rd_exp("R1 bar0 type only", 8'h10, 32'h0);
    rd_exp("R1 bar1 io type", 8'h14, 32'h1);
    rd_exp("R1 bar2 mem64 pref type", 8'h18, 32'hC);
    dec_exp("R1 no decode", 1'b1, 64'h0, 1'b0, 3'd0, 64'd0);
    dec_exp("R1 no io decode", 1'b0, 64'h0, 1'b0, 3'd0, 64'd0);
  endtask

  task automatic t_sizing;
    logic [31:0] d; logic [1:0] st;
    for (int k = 0; k < 6; k++) wr_ok("R2 size write", 8'(8'h10 + 4*k), 2'd2, 32'hFFFF_FFFF);
    rd_exp("R2 mem32 4KiB mask", 8'h10, 32'hFFFF_F000);
    rd_exp("R2 io 256B mask", 8'h14, 32'hFFFF_FF01);
    rd_exp("R2 mem64 pref 1MiB mask", 8'h18, 32'hFFF0_000C);
    rd_exp("R4 upper slot mask", 8'h1C, 32'hFFFF_FFFF);
    rd_exp("R3 8GiB low dword", 8'h20, 32'h0000_0004);
    rd_exp("R3 8GiB upper mask", 8'h24, 32'hFFFF_FFFE);
    cfg_rd(BASE + 16'h11, 2'd0, d, st);
    chk("R2 byte read", 64'(d[7:0]), 64'hF0);
  endtask

  task automatic t_mem32;
    wr_ok("R2 bar0 base", 8'h10, 2'd2, 32'h8000_0000);
    wr_ok("R5 cmd mem", 8'h04, 2'd1, 32'h0000_FFFE);
    rd_exp("R5 cmd readback", 8'h04, 32'h2);
    dec_exp("R6 mem32 hit", 1'b1, 64'h8000_0123, 1'b1, 3'd0, 64'h123);
    dec_exp("R7 past window", 1'b1, 64'h8000_1000, 1'b0, 3'd0, 64'd0);
    dec_exp("R6 wrong space", 1'b0, 64'h8000_0123, 1'b0, 3'd0, 64'd0);
    dec_exp("R4 high bits set on 32-bit window", 1'b1, 64'h1_8000_0123, 1'b0, 3'd0, 64'd0);
  endtask

  task automatic t_io;
    wr_ok("R2 bar1 base", 8'h14, 2'd2, 32'h0000_C000);
    wr_ok("R5 cmd io only", 8'h04, 2'd2, 32'h1);
    dec_exp("R5 io hit", 1'b0, 64'hC0AB, 1'b1, 3'd1, 64'hAB);
    dec_exp("R5 mem gated off", 1'b1, 64'h8000_0123, 1'b0, 3'd0, 64'd0);
    wr_ok("R5 cmd both", 8'h04, 2'd1, 32'h3);
  endtask

  task automatic t_mem64;
    wr_ok("R4 bar2 low", 8'h18, 2'd2, 32'h0020_0000);
    wr_ok("R4 bar2 high", 8'h1C, 2'd2, 32'h0000_0001);
    rd_exp("R4 low readback", 8'h18, 32'h0020_000C);
    rd_exp("R4 high readback", 8'h1C, 32'h1);
    dec_exp("R4 64-bit hit", 1'b1, 64'h1_0020_0042, 1'b1, 3'd2, 64'h42);
    dec_exp("R4 upper mismatch", 1'b1, 64'h0020_0042, 1'b0, 3'd0, 64'd0);
  endtask

  task automatic t_big;
    wr_ok("R3 bar5 high", 8'h24, 2'd2, 32'h0000_0003);
    wr_ok("R3 bar4 low", 8'h20, 2'd2, 32'hFFFF_FFFF);
    rd_exp("R3 low keeps type only", 8'h20, 32'h4);
    rd_exp("R3 high masked", 8'h24, 32'h2);
    dec_exp("R3 8GiB hit", 1'b1, 64'h3_1234_5678, 1'b1, 3'd4, 64'h1_1234_5678);
    dec_exp("R3 beyond window", 1'b1, 64'h4_0000_0000, 1'b0, 3'd0, 64'd0);
  endtask

  task automatic t_move;
    @(negedge clk);
    cfg_valid = 1; cfg_write = 1; cfg_addr = BASE + 16'h10; cfg_size = 2'd2; cfg_wdata = 32'hA000_0000;
    dec_valid = 1; dec_space = 1; dec_addr = 64'h8000_0123;
    #1;
    chk("R8 old base in write cycle", 64'(dec_hit), 64'd1);
    chk("R8 old offset in write cycle", dec_offset, 64'h123);
    @(negedge clk);
    cfg_valid = 0; cfg_write = 0; dec_valid = 0;
    dec_exp("R8 old base gone", 1'b1, 64'h8000_0123, 1'b0, 3'd0, 64'd0);
    dec_exp("R8 new base hits", 1'b1, 64'hA000_0123, 1'b1, 3'd0, 64'h123);
    wr_ok("R8 mem disable", 8'h04, 2'd2, 32'h1);
    dec_exp("R8 disable takes effect", 1'b1, 64'hA000_0123, 1'b0, 3'd0, 64'd0);
    wr_ok("R8 mem enable", 8'h04, 2'd2, 32'h3);
  endtask

  task automatic t_overlap;
    wr_ok("R11 bar2 high clear", 8'h1C, 2'd2, 32'h0);
    wr_ok("R11 bar2 overlap", 8'h18, 2'd2, 32'hA000_0000);
    dec_exp("R11 lowest wins", 1'b1, 64'hA000_0123, 1'b1, 3'd0, 64'h123);
    dec_exp("R11 only bar2", 1'b1, 64'hA000_2000, 1'b1, 3'd2, 64'h2000);
  endtask

  task automatic t_align;
    logic [31:0] d; logic [1:0] st;
    cfg_wr(BASE + 16'h12, 2'd2, 32'hFFFF_FFFF, st);
    chk("R9 dword misaligned write", 64'(st), 64'd1);
    rd_exp("R9 bar0 unchanged", 8'h10, 32'hA000_0000);
    cfg_rd(BASE + 16'h05, 2'd1, d, st);
    chk("R9 half misaligned read", 64'(st), 64'd1);
    cfg_wr(BASE + 16'h04, 2'd3, 32'h0, st);
    chk("R9 bad size code", 64'(st), 64'd1);
    rd_exp("R9 cmd unchanged", 8'h04, 32'h3);
  endtask

  task automatic t_unclaimed;
    logic [31:0] d; logic [1:0] st;
    cfg_wr(16'h1004, 2'd2, 32'h0, st);
    chk("R10 other function", 64'(st), 64'd2);
    cfg_rd(BASE + 16'h100, 2'd2, d, st);
    chk("R10 beyond header", 64'(st), 64'd2);
    cfg_wr(16'h0010, 2'd2, 32'h0, st);
    chk("R10 below base", 64'(st), 64'd2);
    rd_exp("R10 cmd unchanged", 8'h04, 32'h3);
    rd_exp("R10 bar0 unchanged", 8'h10, 32'hA000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset;
    t_sizing;
    t_mem32;
    t_io;
    t_mem64;
    t_big;
    t_move;
    t_overlap;
    t_align;
    t_unclaimed;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule